// File: doc/BRIEF.md
# Sequenced Read-Clear Statistics Bank

This block keeps packet and error totals for a transmit path and a receive path and presents them as six read-only registers, three per direction. Each direction holds a packet count twice as wide as a register, split into a low and a high register, plus an error count one register wide. Event strobes, one per kind and per direction, increment the counts. A read port with an address and a read strobe returns one register per read.

A direction's three registers give a consistent snapshot. The first read of its low packet register freezes the visible counts. Events that arrive during the freeze go into a shadow total. Reading the three registers strictly in ascending order clears the visible counts, and the shadow total becomes the new count. Any other read to that direction's registers during the sequence cancels the clear: the shadow total is folded back in and nothing is lost. Counts stop at all-ones and do not wrap.

Top module: `stat_bank`

## Requirements
- R1: Read addresses are mapped as follows. Address 1 returns transmit packets [REG_W-1:0], 2 returns transmit packets [2*REG_W-1:REG_W], and 3 returns transmit errors. Addresses 4, 5 and 6 return the same three fields for receive. Any other address returns zero. `rd_data` is registered: it is updated at the clock edge where `rd_en` is high, holds the visible value from before that edge, and otherwise keeps its value.
- R2: Each strobe that is high at a clock edge adds exactly one to its count. Packet counts carry from the low register into the high register.
- R3: A read of a direction's first address while that direction is idle freezes its visible counts and starts a sequence. Events that arrive from that edge onward do not change the visible counts until the sequence ends.
- R4: Reading first, second and third address of a direction in consecutive accesses to that direction clears it. The events gathered during the freeze, including any at the final edge, become its new counts.
- R5: During a sequence, a read of the direction's own registers that is not the next expected one aborts the sequence without clearing. Frozen events are added to the counts. The aborting read, even of the first address, leaves the direction idle (so 1,2,1,2,3 clears nothing).
- R6: While a direction is idle, reads of its second or third address return live values and change no state.
- R7: Counts and shadow totals saturate at all-ones.
- R8: Transmit and receive keep separate sequence state. Reads to one direction or to unused addresses never advance or abort the other.
- R9: After reset all counts, shadow totals and `rd_data` are zero and both directions are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pkt | input | 1 | Transmit packet event strobe |
| tx_err | input | 1 | Transmit error event strobe |
| rx_pkt | input | 1 | Receive packet event strobe |
| rx_err | input | 1 | Receive error event strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Register index |
| rd_data | output | REG_W | Registered read data |

## Verification
The bench builds the bank with REG_W = 4, so a packet count is 8 bits and an error count is 4 bits. With these widths, a carry into the high register appears after 16 packets, and both counts reach saturation within a few hundred strobes. This holds for the visible counts and for the shadow totals gathered during a freeze. The bench also tests interleaved transmit and receive sequences, aborts that use the first address, and an abort that folds shadowed events back in.

// File: rtl/stat_pkg.sv
package stat_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WANT_MID  = 2'd1,
    SEQ_WANT_LAST = 2'd2
  } seq_e;
endpackage

// File: rtl/sat_accum.sv
module sat_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         hold,
  input  logic         clr,
  input  logic         abt,
  output logic [W-1:0] value
);
  logic [W-1:0] main_q, shad_q, inc_w;

  function automatic logic [W-1:0] sat_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  assign inc_w = {{(W-1){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= '0;
      shad_q <= '0;
    end else if (clr) begin
      main_q <= sat_sum(shad_q, inc_w);
      shad_q <= '0;
    end else if (abt) begin
      main_q <= sat_sum(sat_sum(main_q, shad_q), inc_w);
      shad_q <= '0;
    end else if (hold) begin
      shad_q <= sat_sum(shad_q, inc_w);
    end else begin
      main_q <= sat_sum(main_q, inc_w);
    end
  end

  assign value = main_q;

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == {W{1'b1}} && !clr) |=> main_q == {W{1'b1}});
  a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr && !abt) |=> $stable(main_q));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clr && !abt && !inc) |=> $stable(main_q));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_hit,
  input  logic [1:0] rd_sel,
  output logic       start,
  output logic       clr,
  output logic       abt,
  output logic       busy
);
  seq_e state_q, state_d;

  always_comb begin
    start   = 1'b0;
    clr     = 1'b0;
    abt     = 1'b0;
    state_d = state_q;
    case (state_q)
      SEQ_IDLE:
        if (rd_hit && rd_sel == 2'd0) begin
          start   = 1'b1;
          state_d = SEQ_WANT_MID;
        end
      SEQ_WANT_MID:
        if (rd_hit) begin
          if (rd_sel == 2'd1) state_d = SEQ_WANT_LAST;
          else begin
            abt     = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
      SEQ_WANT_LAST:
        if (rd_hit) begin
          if (rd_sel == 2'd2) clr = 1'b1;
          else abt = 1'b1;
          state_d = SEQ_IDLE;
        end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != SEQ_IDLE);

  a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abt |=> state_q == SEQ_IDLE);
  a_r4_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> state_q == SEQ_IDLE);
  a_r3_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, clr, abt}));
  a_r8_no_hit_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(state_q));
endmodule

// File: rtl/stat_group.sv
module stat_group #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_ev,
  input  logic             err_ev,
  input  logic             rd_hit,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] field
);
  localparam int PKT_W = 2 * REG_W;

  logic             start, clr, abt, busy, hold;
  logic [PKT_W-1:0] pkt_val;
  logic [REG_W-1:0] err_val;

  seq_ctrl u_seq (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_sel(rd_sel),
    .start(start), .clr(clr), .abt(abt), .busy(busy)
  );

  assign hold = start | busy;

  sat_accum #(.W(PKT_W)) u_pkt (
    .clk(clk), .rst_n(rst_n), .inc(pkt_ev), .hold(hold),
    .clr(clr), .abt(abt), .value(pkt_val)
  );

  sat_accum #(.W(REG_W)) u_err (
    .clk(clk), .rst_n(rst_n), .inc(err_ev), .hold(hold),
    .clr(clr), .abt(abt), .value(err_val)
  );

  always_comb begin
    case (rd_sel)
      2'd0:    field = pkt_val[REG_W-1:0];
      2'd1:    field = pkt_val[PKT_W-1:REG_W];
      2'd2:    field = err_val;
      default: field = '0;
    endcase
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_pkt,
  input  logic              tx_err,
  input  logic              rx_pkt,
  input  logic              rx_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int NGRP = 2;
  localparam int NREG = 3;

  logic [NGRP-1:0]  ev_pkt, ev_err, hit;
  logic [REG_W-1:0] field [NGRP];
  logic [REG_W-1:0] rd_next;

  assign ev_pkt = {rx_pkt, tx_pkt};
  assign ev_err = {rx_err, tx_err};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(1 + NREG * g);
    logic [ADDR_W-1:0] off;
    assign off    = rd_addr - BASE;
    assign hit[g] = rd_en && (rd_addr >= BASE) && (off < ADDR_W'(NREG));

    stat_group #(.REG_W(REG_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .pkt_ev(ev_pkt[g]), .err_ev(ev_err[g]),
      .rd_hit(hit[g]), .rd_sel(off[1:0]), .field(field[g])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NGRP; g++)
      if (hit[g]) rd_next = field[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit == '0) |=> rd_data == '0);
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  a_r8_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/stat_bank_bench.sv
module stat_bank_bench;
  localparam int REG_W  = 4;
  localparam int ADDR_W = 3;
  localparam int NV     = 33;

  logic clk = 1'b0;
  logic rst_n, tx_pkt, tx_err, rx_pkt, rx_err, rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [REG_W-1:0]  rd_data;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stat_bank #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_stat_bank (
    .clk(clk), .rst_n(rst_n), .tx_pkt(tx_pkt), .tx_err(tx_err),
    .rx_pkt(rx_pkt), .rx_err(rx_err), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // row: {tx_pkt, tx_err, rx_pkt, rx_err, rd_en, addr, expected}
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000, 1'b1, 3'd1, 4'd0},  // R9 reset zero, start tx
    {4'b0000, 1'b1, 3'd2, 4'd0},
    {4'b0000, 1'b1, 3'd3, 4'd0},  // R4 clear
    {4'b1110, 1'b0, 3'd0, 4'd0},  // R2 events
    {4'b1010, 1'b0, 3'd0, 4'd0},
    {4'b1000, 1'b0, 3'd0, 4'd0},
    {4'b1000, 1'b1, 3'd1, 4'd3},  // R3 snapshot, event shadowed
    {4'b1000, 1'b1, 3'd4, 4'd2},  // R8 interleave rx start
    {4'b0100, 1'b1, 3'd2, 4'd0},
    {4'b0000, 1'b1, 3'd5, 4'd0},
    {4'b0000, 1'b1, 3'd3, 4'd1},  // R4 tx clear keeps shadow
    {4'b0000, 1'b1, 3'd6, 4'd0},
    {4'b0000, 1'b1, 3'd1, 4'd2},  // R4 shadow became count
    {4'b0000, 1'b1, 3'd3, 4'd1},  // R5 skip aborts
    {4'b0000, 1'b1, 3'd2, 4'd0},  // R6 idle read
    {4'b0000, 1'b1, 3'd1, 4'd2},  // R5 not cleared
    {4'b0000, 1'b1, 3'd2, 4'd0},
    {4'b0000, 1'b1, 3'd1, 4'd2},  // R5 repeat first aborts
    {4'b0000, 1'b1, 3'd2, 4'd0},
    {4'b0000, 1'b1, 3'd3, 4'd1},
    {4'b0000, 1'b1, 3'd1, 4'd2},  // R5 1,2,1,2,3 left counts
    {4'b0000, 1'b1, 3'd2, 4'd0},
    {4'b0000, 1'b1, 3'd3, 4'd1},
    {4'b0000, 1'b1, 3'd1, 4'd0},  // R4 cleared
    {4'b0000, 1'b1, 3'd2, 4'd0},
    {4'b0000, 1'b1, 3'd3, 4'd0},
    {4'b0010, 1'b1, 3'd4, 4'd0},  // R3 rx freeze
    {4'b0010, 1'b1, 3'd4, 4'd0},  // R5 abort merges shadow
    {4'b0000, 1'b1, 3'd4, 4'd2},
    {4'b0000, 1'b1, 3'd5, 4'd0},
    {4'b0000, 1'b1, 3'd6, 4'd0},
    {4'b0000, 1'b1, 3'd0, 4'd0},  // R1 unused address
    {4'b0000, 1'b1, 3'd7, 4'd0}   // R1 unused address
  };

  task automatic check(input string req, input logic [REG_W-1:0] got, input logic [REG_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic tp, input logic te, input logic rp, input logic re,
                       input logic rd, input logic [ADDR_W-1:0] a);
    tx_pkt = tp; tx_err = te; rx_pkt = rp; rx_err = re;
    rd_en = rd; rd_addr = a;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] exp);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a);
    check(req, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tx_pkt = 0; tx_err = 0; rx_pkt = 0; rx_err = 0; rd_en = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R9 rd_data after reset", rd_data, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:4]);
      if (VEC[i][7]) check($sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R8)", i), rd_data, VEC[i][3:0]);
    end

    // R2 carry into high register: 20 packets, 3 errors
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b1, i < 3, 1'b0, '0);
    rd_chk("R2 rx low", 3'd4, 4'h4);
    rd_chk("R2 rx high", 3'd5, 4'h1);
    rd_chk("R2 rx err", 3'd6, 4'h3);

    // R7 saturation of visible counts
    for (int i = 0; i < 300; i++) cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    rd_chk("R7 rx low sat", 3'd4, 4'hF);
    rd_chk("R7 rx high sat", 3'd5, 4'hF);
    rd_chk("R7 rx err sat", 3'd6, 4'hF);

    // R7 saturation of the shadow total during a freeze
    rd_chk("R4 rx cleared", 3'd4, 4'h0);
    for (int i = 0; i < 300; i++) cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    rd_chk("R3 rx high frozen", 3'd5, 4'h0);
    rd_chk("R3 rx err frozen", 3'd6, 4'h0);
    rd_chk("R7 shadow low sat", 3'd4, 4'hF);
    rd_chk("R7 shadow high sat", 3'd5, 4'hF);
    rd_chk("R7 shadow err sat", 3'd6, 4'hF);

    // R8 tx untouched by all receive traffic
    rd_chk("R8 tx low", 3'd1, 4'h0);
    rd_chk("R8 tx high", 3'd2, 4'h0);
    rd_chk("R8 tx err", 3'd3, 4'h0);

    // R1 rd_data holds without a read
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1);
    check("R1 hold without read", rd_data, 4'h0);

    finish_run();
  end
endmodule